// File: doc/BRIEF.md
# Refresh-Merging Memory Access Controller

This block fronts a 1024-word main store whose cells lose their contents unless each row is rewritten at regular intervals. The store is modelled as 40 bit-planes sharing one address, each plane a 32 by 32 array. One processor port issues single-word reads and writes. A controller keeps a row pointer that moves through all 32 rows. It tries to do each row's refresh as a side effect of an ordinary access, and takes a dedicated cycle only when none comes in time.

A free-running timer marks the pointer row as due once per refresh interval. If the processor accepts a read or write to that row within a grace window, the refresh counts as done at no cost. If no such access arrives, the controller blocks the port for one cycle and refreshes the row alone. Either way the pointer then advances. The store model tracks the age of every row. A word in a row left unrefreshed for longer than one full rotation plus margin reads back bit-inverted, so a starved row shows up as wrong data.

Top module: `refresh_merge_mem`

## Requirements
- R1: The 10-bit address splits into row = addr[9:5] and column = addr[4:0]. All 1024 locations hold independent 40-bit words, and a write replaces all 40 bits.
- R2: While req is high, ack is high in the same cycle unless a forced refresh cycle is in progress. The access takes effect at the clock edge that ends that cycle, and a read accepted in the next cycle returns the written value.
- R3: A read accepted at an edge drives rdata and raises rvalid for exactly the one following cycle. A write never raises rvalid.
- R4: A refresh falls due every REFRESH_INTERVAL cycles, the first at the REFRESH_INTERVAL-th edge after reset. The pointer starts at row 0, advances by one per completed refresh and wraps from 31 to 0.
- R5: An accepted read or write to the due row, no later than the edge REFRESH_DEADLINE cycles after the due edge, completes the refresh, and the port is never stalled for it.
- R6: If no such access occurs, ack is held low for exactly one cycle: the cycle after the edge REFRESH_DEADLINE cycles past the due edge.
- R7: A request held through a forced refresh cycle is accepted in the cycle right after it.
- R8: Stored words stay intact across idle periods of any length, because every row is refreshed before it reaches its decay age.
- R9: After reset, rvalid is low, rdata is zero, and ack is low while req is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Access request, held until ack |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Word address: row in upper 5 bits, column in lower 5 |
| wdata | input | 40 | Word to store |
| ack | output | 1 | Request accepted this cycle |
| rvalid | output | 1 | rdata holds a read result this cycle |
| rdata | output | 40 | Read result |

## Verification
Acceptance is combinational, so the bench drives inputs on the falling edge and samples ack 1 time unit later, in the same cycle. Read data and rvalid are registered once, so they are checked on the falling edge after the accepting edge. The bench counts rising edges since reset itself. A due edge is then a multiple of the interval, and a forced stall must fall exactly where the edge count modulo the interval equals the deadline. In merge mode, ack is checked for every cycle of many windows. Retention is checked by a full write, an idle stretch of three rotations and a full read-back.

// File: rtl/refresh_merge_mem.sv
module refresh_merge_mem #(
  parameter int WORD_W           = 40,
  parameter int ROW_W            = 5,
  parameter int COL_W            = 5,
  parameter int REFRESH_INTERVAL = 16,
  parameter int REFRESH_DEADLINE = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   we,
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [WORD_W-1:0]      wdata,
  output logic                   ack,
  output logic                   rvalid,
  output logic [WORD_W-1:0]      rdata
);

  localparam int ADDR_W    = ROW_W + COL_W;
  localparam int ROWS      = 1 << ROW_W;
  localparam int WORDS     = 1 << ADDR_W;
  localparam int AGE_LIMIT = ROWS * REFRESH_INTERVAL + REFRESH_DEADLINE + 2;
  localparam int AGE_W     = $clog2(AGE_LIMIT + 1);
  localparam int TMR_W     = $clog2(REFRESH_INTERVAL);
  localparam int DL_W      = $clog2(REFRESH_DEADLINE + 1);

  logic [TMR_W-1:0]  tmr_q;
  logic [DL_W-1:0]   dl_q;
  logic              pend_q, frc_q;
  logic [ROW_W-1:0]  ptr_q;
  logic [WORD_W-1:0] mem [WORDS];
  logic [WORDS-1:0]  stale_q;
  logic [AGE_W-1:0]  age_q [ROWS];
  logic [ROWS-1:0]   row_decay;
  logic              rvalid_q;
  logic [WORD_W-1:0] rdata_q;

  wire [ROW_W-1:0] acc_row   = addr[ADDR_W-1:COL_W];
  wire             tick      = (tmr_q == TMR_W'(REFRESH_INTERVAL - 1));
  wire             merge     = pend_q & ack & (acc_row == ptr_q);
  wire             expire    = pend_q & ~merge & (dl_q == DL_W'(REFRESH_DEADLINE - 1));
  wire             rfsh_done = merge | frc_q;

  assign ack    = req & ~frc_q;
  assign rvalid = rvalid_q;
  assign rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q  <= '0;
      dl_q   <= '0;
      pend_q <= 1'b0;
      frc_q  <= 1'b0;
      ptr_q  <= '0;
    end else begin
      tmr_q <= tick ? '0 : tmr_q + 1'b1;
      frc_q <= expire;
      if (merge || expire)  pend_q <= 1'b0;
      else if (tick)        pend_q <= 1'b1;
      if (!pend_q || merge || expire) dl_q <= '0;
      else                            dl_q <= dl_q + 1'b1;
      if (rfsh_done) ptr_q <= ptr_q + 1'b1;
    end
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_age
    wire hit = rfsh_done && (ptr_q == ROW_W'(r));
    always_ff @(posedge clk) begin
      if (!rst_n)                              age_q[r] <= '0;
      else if (hit)                            age_q[r] <= '0;
      else if (age_q[r] != AGE_W'(AGE_LIMIT))  age_q[r] <= age_q[r] + 1'b1;
    end
    assign row_decay[r] = !hit && (age_q[r] == AGE_W'(AGE_LIMIT - 1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stale_q <= '0;
    end else begin
      for (int w = 0; w < WORDS; w++) begin
        if (ack && we && addr == ADDR_W'(w)) stale_q[w] <= 1'b0;
        else if (row_decay[w >> COL_W])      stale_q[w] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (ack && we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= ack & ~we;
      if (ack && !we) rdata_q <= stale_q[addr] ? ~mem[addr] : mem[addr];
    end
  end

  AST_READ_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (req && ack && !we) |=> rvalid); // R3
  AST_VALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> $past(req && ack && !we)); // R3
  AST_PTR_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q != $past(ptr_q)) |-> (ptr_q == $past(ptr_q) + 1'b1)); // R4
  AST_MERGE_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    merge |=> !frc_q); // R5
  AST_EXPIRE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (frc_q && !pend_q)); // R6
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frc_q |=> !frc_q); // R6
  AST_PEND_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (dl_q < DL_W'(REFRESH_DEADLINE))); // R6
  AST_HELD_REQ_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !ack) |=> (!req || ack)); // R7
  AST_NO_ROW_DECAY: assert property (@(posedge clk) disable iff (!rst_n)
    row_decay == '0); // R8

endmodule

// File: tb/refresh_merge_mem_bench.sv
module refresh_merge_mem_bench;
  localparam int CLK_PERIOD = 10;
  localparam int INTERVAL   = 16;
  localparam int DEADLINE   = 6;
  localparam int NROWS      = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [9:0]  addr = '0;
  logic [39:0] wdata = '0;
  logic        ack, rvalid;
  logic [39:0] rdata;
  int          checks = 0;
  int          errors = 0;
  int          ecount = 0;

  refresh_merge_mem #(.REFRESH_INTERVAL(INTERVAL), .REFRESH_DEADLINE(DEADLINE)) u_refresh_merge_mem (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .ack(ack), .rvalid(rvalid), .rdata(rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (rst_n) ecount <= ecount + 1;
    else       ecount <= 0;
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual %0h expected %0h", tag, ecount, act, exp);
    end
  endtask

  function automatic logic [39:0] pat(input int a);
    logic [9:0] x;
    x = a[9:0];
    return {x, ~x, {x[4:0], x[9:5]}, x ^ 10'h155};
  endfunction

  task automatic do_write(input logic [9:0] a, input logic [39:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1;
    while (!ack) begin @(negedge clk); #1; end
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic do_read(input logic [9:0] a, input logic [39:0] exp, input string tag);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1;
    while (!ack) begin @(negedge clk); #1; end
    @(negedge clk);
    req = 1'b0;
    #1;
    chk(rvalid === 1'b1, "R3 rvalid after read", 64'(rvalid), 64'd1);
    chk(rdata === exp, tag, 64'(rdata), 64'(exp));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req = 1'b0; we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(rvalid === 1'b0, "R9 rvalid after reset", 64'(rvalid), 64'd0);
    chk(rdata === '0, "R9 rdata after reset", 64'(rdata), 64'd0);
    chk(ack === 1'b0, "R9 ack idle", 64'(ack), 64'd0);
    req = 1'b1; addr = '0;
    #1;
    chk(ack === 1'b1, "R2 same-cycle ack", 64'(ack), 64'd1);
    req = 1'b0;
  endtask

  task automatic t_read_pulse;
    logic [39:0] v;
    v = 40'hA5_0F0F_C33C;
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 10'd5; wdata = v;
    #1;
    while (!ack) begin @(negedge clk); #1; end
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = 10'd5;
    #1;
    chk(rvalid === 1'b0, "R3 no rvalid for write", 64'(rvalid), 64'd0);
    while (!ack) begin @(negedge clk); #1; end
    @(negedge clk);
    req = 1'b0;
    #1;
    chk(rvalid === 1'b1, "R3 rvalid pulse", 64'(rvalid), 64'd1);
    chk(rdata === v, "R2 write visible next cycle", 64'(rdata), 64'(v));
    @(negedge clk);
    #1;
    chk(rvalid === 1'b0, "R3 pulse lasts one cycle", 64'(rvalid), 64'd0);
    do_write(10'd5, 40'h0);
    do_read(10'd5, 40'h0, "R1 whole word replaced");
  endtask

  task automatic t_merge_every;
    repeat (INTERVAL * 40) begin
      @(negedge clk);
      req = 1'b1; we = 1'b0;
      addr = {5'((ecount / INTERVAL + NROWS - 1) % NROWS), 5'd9};
      #1;
      chk(ack === 1'b1, "R5/R4 merged refresh never stalls", 64'(ack), 64'd1);
    end
    req = 1'b0;
  endtask

  task automatic t_late_merge;
    repeat (INTERVAL * 8) begin
      int n;
      @(negedge clk);
      n = ecount / INTERVAL;
      req = 1'b1; we = 1'b0;
      if (ecount % INTERVAL == DEADLINE - 1) addr = {5'((n + NROWS - 1) % NROWS), 5'd3};
      else                                   addr = {5'((n + 15) % NROWS), 5'd3};
      #1;
      chk(ack === 1'b1, "R5 last-chance merge", 64'(ack), 64'd1);
    end
    req = 1'b0;
  endtask

  task automatic t_forced;
    repeat (INTERVAL * 8) begin
      bit stall;
      @(negedge clk);
      req = 1'b1; we = 1'b0;
      addr = {5'((ecount / INTERVAL + 15) % NROWS), 5'd17};
      stall = (ecount >= INTERVAL) && (ecount % INTERVAL == DEADLINE);
      #1;
      chk(ack === !stall, stall ? "R6 forced stall cycle" : "R7 ack outside stall",
          64'(ack), 64'(!stall));
    end
    req = 1'b0;
  endtask

  task automatic t_retention;
    for (int a = 0; a < 1024; a++) do_write(10'(a), pat(a));
    for (int a = 0; a < 1024; a += 37) do_read(10'(a), pat(a), "R1 readback");
    repeat (3 * (NROWS + 1) * INTERVAL + 50) @(negedge clk);
    for (int a = 0; a < 1024; a++) do_read(10'(a), pat(a), "R8 retained after idle");
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    finish_run();
  end

  initial begin
    t_reset();
    t_read_pulse();
    t_merge_every();
    t_late_merge();
    t_forced();
    t_retention();
    finish_run();
  end
endmodule